// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Port

This block is a 32-pin general-purpose I/O port with a small synchronous register bus. Each pin has an output value and an output-enable bit. The level seen on each pad can be read back whatever the pin's direction. Every pin also feeds an event detector. Software sets the detector, per pin, to a low level, a high level, a rising edge or a falling edge. Detected events are held in a sticky status register, and writing ones to that register clears them.

The interrupt mask gates the status. The low sixteen pins drive one interrupt line and the high sixteen drive another. A third line ORs the two together, for a system that wires only one interrupt. Pad inputs pass through a two-stage synchronizer before detection. Edges are found by comparing the synchronized level with its value one cycle earlier.

The bus is single-cycle. A write happens on the clock edge where `bus_sel` and `bus_wr` are both high. Read data is combinational from `bus_addr` while `bus_sel` is high, and is zero otherwise.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset is low, every register reads zero, `pad_oe` and `pad_out` are zero, and all three interrupt lines are low.
- R2: A write to offset 0x00 sets `pad_out`, and a write to offset 0x04 sets `pad_oe` (1 = pin driven). Both read back at their offsets, and neither port changes without a write.
- R3: Offset 0x08 returns the pad levels after two clock edges of synchronization, whatever the direction bits hold.
- R4: Offset 0x0C holds the trigger fields for pins 0..15 and offset 0x10 holds those for pins 16..31. Pin n uses bits [2*(n%16)+1 : 2*(n%16)] of its register, and both registers read back as written.
- R5: Trigger code 0 sets the pin's status bit on every cycle that its synchronized level is 0, and code 1 does the same while the level is 1.
- R6: Trigger code 2 sets the status bit once, on a synchronized 0-to-1 change. Code 3 sets it once, on a 1-to-0 change. An edge of the other polarity sets nothing.
- R7: Writing a 1 to a bit of offset 0x18 clears that status bit, and writing 0 leaves it unchanged. An edge event stays cleared after the write.
- R8: When a new event and a clear hit the same status bit in the same cycle, the bit stays set. So a level condition that persists cannot be cleared.
- R9: Offset 0x14 is the mask (1 = enabled). `irq_lo` is the OR of status AND mask over pins 0..15, and `irq_hi` is the same over pins 16..31.
- R10: `irq_any` equals `irq_lo` OR `irq_hi`.
- R11: Writes to the pad-level register or to an unmapped offset change nothing. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| pad_in | input | 32 | Pad input levels |
| pad_out | output | 32 | Values driven on output pins |
| pad_oe | output | 32 | Output enables, 1 = driven |
| irq_lo | output | 1 | Interrupt for pins 0..15 |
| irq_hi | output | 1 | Interrupt for pins 16..31 |
| irq_any | output | 1 | OR of both interrupt lines |

## Verification
A status bit that is wrongly set or wrongly kept shows up on the masked interrupt line in the same cycle. It also shows up in a status read straight after the clear write that should have removed it. A synchronizer that is too short or too long moves the pad-level readback by one edge, and the bench samples exactly at edge two. A trigger field decoded from the wrong bits or the wrong register makes a pin react to the opposite polarity, or to nothing. That appears within three edges of the stimulus.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_e;

  localparam int unsigned ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_OUTVAL = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_OUTEN  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_LEVEL  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_TRG_LO = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_TRG_HI = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_ENABLE = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_EVENTS = 5'h18;

  // Decide whether one pin raises an event this cycle.
  function automatic logic trig_hit(input trig_e mode, input logic cur, input logic prev);
    logic hit;
    unique case (mode)
      TRIG_LOW:  hit = ~cur;
      TRIG_HIGH: hit = cur;
      TRIG_RISE: hit = cur & ~prev;
      TRIG_FALL: hit = ~cur & prev;
      default:   hit = 1'b0;
    endcase
    return hit;
  endfunction

  // Next status value: clear first, then merge events so an event wins.
  function automatic logic [31:0] status_next(input logic [31:0] cur,
                                              input logic [31:0] clr,
                                              input logic [31:0] evt);
    return (cur & ~clr) | evt;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] lvl,
  output logic [W-1:0] lvl_prev
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;
  logic [W-1:0] hist;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
      hist   <= '0;
    end else begin
      stage1 <= raw;
      stage2 <= stage1;
      hist   <= stage2;
    end
  end

  assign lvl      = stage2;
  assign lvl_prev = hist;
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned W    = 32,
  parameter int unsigned HALF = W / 2
) (
  input  logic [2*HALF-1:0] trg_lo,
  input  logic [2*HALF-1:0] trg_hi,
  input  logic [W-1:0]      lvl,
  input  logic [W-1:0]      lvl_prev,
  output logic [W-1:0]      evt
);
  for (genvar g = 0; g < W; g++) begin : g_pin
    trig_e mode;
    if (g < HALF) begin : g_low
      assign mode = trig_e'(trg_lo[2*g +: 2]);
    end else begin : g_high
      assign mode = trig_e'(trg_hi[2*(g-HALF) +: 2]);
    end
    assign evt[g] = trig_hit(mode, lvl[g], lvl_prev[g]);
  end
endmodule

// File: rtl/gpio_evt_status.sv
module gpio_evt_status
  import gpio_irq_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] clr,
  output logic [W-1:0] status
);
  logic [31:0] nxt;

  always_comb begin
    nxt = status_next(32'(status), 32'(clr), 32'(evt));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= nxt[W-1:0];
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int unsigned PINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe,
  output logic              irq_lo,
  output logic              irq_hi,
  output logic              irq_any
);
  localparam int unsigned HALF  = PINS / 2;
  localparam int unsigned CFG_W = 2 * HALF;

  logic [PINS-1:0]  outval_q, outen_q, enable_q;
  logic [CFG_W-1:0] trg_lo_q, trg_hi_q;
  logic [PINS-1:0]  lvl, lvl_prev;
  logic [PINS-1:0]  evt, clr, status;
  logic [PINS-1:0]  pending;
  logic             wr_hit;

  assign wr_hit = bus_sel & bus_wr;
  assign clr    = (wr_hit && bus_addr == OFS_EVENTS) ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outval_q <= '0;
      outen_q  <= '0;
      enable_q <= '0;
      trg_lo_q <= '0;
      trg_hi_q <= '0;
    end else if (wr_hit) begin
      unique case (bus_addr)
        OFS_OUTVAL: outval_q <= bus_wdata;
        OFS_OUTEN:  outen_q  <= bus_wdata;
        OFS_TRG_LO: trg_lo_q <= bus_wdata[CFG_W-1:0];
        OFS_TRG_HI: trg_hi_q <= bus_wdata[CFG_W-1:0];
        OFS_ENABLE: enable_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  gpio_in_sync #(.W(PINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw      (pad_in),
    .lvl      (lvl),
    .lvl_prev (lvl_prev)
  );

  gpio_trig_detect #(.W(PINS), .HALF(HALF)) u_detect (
    .trg_lo   (trg_lo_q),
    .trg_hi   (trg_hi_q),
    .lvl      (lvl),
    .lvl_prev (lvl_prev),
    .evt      (evt)
  );

  gpio_evt_status #(.W(PINS)) u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (evt),
    .clr    (clr),
    .status (status)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      unique case (bus_addr)
        OFS_OUTVAL: bus_rdata = outval_q;
        OFS_OUTEN:  bus_rdata = outen_q;
        OFS_LEVEL:  bus_rdata = lvl;
        OFS_TRG_LO: bus_rdata = PINS'(trg_lo_q);
        OFS_TRG_HI: bus_rdata = PINS'(trg_hi_q);
        OFS_ENABLE: bus_rdata = enable_q;
        OFS_EVENTS: bus_rdata = status;
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign pending = status & enable_q;
  assign irq_lo  = |pending[HALF-1:0];
  assign irq_hi  = |pending[PINS-1:HALF];
  assign irq_any = irq_lo | irq_hi;
  assign pad_out = outval_q;
  assign pad_oe  = outen_q;
endmodule

// File: rtl/gpio_irq_checker.sv
module gpio_irq_checker #(
  parameter int unsigned PINS = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_hit,
  input logic [PINS-1:0] evt,
  input logic [PINS-1:0] clr,
  input logic [PINS-1:0] status,
  input logic [PINS-1:0] enable_q,
  input logic [PINS-1:0] pad_oe,
  input logic            irq_lo,
  input logic            irq_hi,
  input logic            irq_any
);
  localparam int unsigned HALF = PINS / 2;

  p_dir_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_hit) |-> $stable(pad_oe));

  p_set_needs_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(status) & ~$past(evt)) == '0));

  p_clear_takes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~evt) != '0) |=> ((status & $past(clr & ~evt)) == '0));

  p_event_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((status & $past(evt)) == $past(evt)));

  p_lo_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lo |-> ((status[HALF-1:0] & enable_q[HALF-1:0]) != '0));

  p_hi_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((status[PINS-1:HALF] & enable_q[PINS-1:HALF]) != '0) |-> irq_hi);

  p_combined_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any == (irq_lo | irq_hi));
endmodule

bind gpio_irq_port gpio_irq_checker #(.PINS(PINS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_hit   (wr_hit),
  .evt      (evt),
  .clr      (clr),
  .status   (status),
  .enable_q (enable_q),
  .pad_oe   (pad_oe),
  .irq_lo   (irq_lo),
  .irq_hi   (irq_hi),
  .irq_any  (irq_any)
);

// File: tb/tb_gpio_irq_port.sv
`timescale 1ns/1ps
module tb_gpio_irq_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] pad_in = 32'hFFFF_FFFF, pad_out, pad_oe;
  logic        irq_lo, irq_hi, irq_any;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_port dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .irq_lo(irq_lo), .irq_hi(irq_hi), .irq_any(irq_any)
  );

  // {offset, write value, expected readback at the same offset}
  localparam logic [68:0] TBL [7] = '{
    {5'h00, 32'hA5A5_0F0F, 32'hA5A5_0F0F},  // R2 output value
    {5'h04, 32'hFFFF_0000, 32'hFFFF_0000},  // R2 output enable
    {5'h0C, 32'h1234_5678, 32'h1234_5678},  // R4 low trigger word
    {5'h10, 32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R4 high trigger word
    {5'h14, 32'h8000_0001, 32'h8000_0001},  // R9 mask
    {5'h08, 32'h0000_0000, 32'hFFFF_FFFF},  // R11 level reg is read-only
    {5'h1C, 32'hFFFF_FFFF, 32'h0000_0000}   // R11 unmapped offset
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at a falling edge.
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    // R1: reset state
    idle(3);
    for (int a = 0; a < 32; a += 4) begin
      rd(5'(a), v);
      check("R1 register in reset", v, 32'h0);
    end
    check("R1 pad_oe", pad_oe, 32'h0);
    check("R1 pad_out", pad_out, 32'h0);
    check("R1 irq lines", {29'h0, irq_lo, irq_hi, irq_any}, 32'h0);
    rst_n = 1'b1;
    idle(4);

    // Table walk: write then read back
    for (int i = 0; i < 7; i++) begin
      wr(TBL[i][68:64], TBL[i][63:32]);
      rd(TBL[i][68:64], v);
      check("R2/R4/R9/R11 table readback", v, TBL[i][31:0]);
    end
    check("R2 pad_out port", pad_out, 32'hA5A5_0F0F);
    check("R2 pad_oe port", pad_oe, 32'hFFFF_0000);
    rd(5'h00, v); check("R11 data untouched by unmapped write", v, 32'hA5A5_0F0F);

    // Quiet state: level-low everywhere, pads high, nothing masked
    wr(5'h14, 32'h0); wr(5'h0C, 32'h0); wr(5'h10, 32'h0);
    idle(2);
    wr(5'h18, 32'hFFFF_FFFF);
    rd(5'h18, v); check("R7 clear all", v, 32'h0);

    // R3: two-edge latency, independent of direction
    wr(5'h04, 32'hFFFF_FFFF);
    pad_in[9] = 1'b0;
    @(negedge clk); rd(5'h08, v); check("R3 after one edge", v, 32'hFFFF_FFFF);
    @(negedge clk); rd(5'h08, v); check("R3 after two edges", v, 32'hFFFF_FDFF);
    pad_in[9] = 1'b1;
    wr(5'h04, 32'h0);
    idle(4); wr(5'h18, 32'hFFFF_FFFF);

    // R5/R8: level low on pin 3, masked
    wr(5'h14, 32'h0000_0008);
    pad_in[3] = 1'b0;
    idle(4);
    rd(5'h18, v); check("R5 low level sets", v, 32'h0000_0008);
    check("R9 irq_lo on", {31'h0, irq_lo}, 32'h1);
    check("R10 irq_any follows lo", {31'h0, irq_any}, 32'h1);
    wr(5'h18, 32'h0000_0000);
    rd(5'h18, v); check("R7 zero write keeps bit", v, 32'h0000_0008);
    wr(5'h18, 32'h0000_0008);
    rd(5'h18, v); check("R8 level persists over clear", v, 32'h0000_0008);
    pad_in[3] = 1'b1;
    idle(4);
    wr(5'h18, 32'h0000_0008);
    rd(5'h18, v); check("R7 cleared once level gone", v, 32'h0);
    check("R9 irq_lo off", {31'h0, irq_lo}, 32'h0);

    // R5/R9/R10: high level on pin 20 (field 4 of high word)
    wr(5'h14, 32'h0010_0000);
    wr(5'h10, 32'h0000_0100);
    idle(1);
    rd(5'h18, v); check("R5 high level sets pin 20", v, 32'h0010_0000);
    check("R9 irq_hi/irq_lo", {30'h0, irq_hi, irq_lo}, 32'h2);
    check("R10 irq_any follows hi", {31'h0, irq_any}, 32'h1);
    wr(5'h14, 32'h0000_0000);
    check("R9 mask off drops irq_hi", {31'h0, irq_hi}, 32'h0);
    wr(5'h10, 32'h0);
    wr(5'h18, 32'hFFFF_FFFF);

    // R6: pin 5 rising (code 2), pin 6 falling (code 3)
    wr(5'h0C, 32'h0000_3800);
    idle(2);
    wr(5'h18, 32'hFFFF_FFFF);
    rd(5'h18, v); check("R6 static pads give nothing", v, 32'h0);
    pad_in[5] = 1'b0;
    idle(4);
    rd(5'h18, v); check("R6 falling ignored by rising pin", v, 32'h0);
    pad_in[5] = 1'b1;
    idle(4);
    rd(5'h18, v); check("R6 rising detected", v, 32'h0000_0020);
    wr(5'h18, 32'h0000_0020);
    idle(2);
    rd(5'h18, v); check("R7 edge stays cleared", v, 32'h0);
    pad_in[6] = 1'b0;
    idle(4);
    rd(5'h18, v); check("R6 falling detected", v, 32'h0000_0040);
    pad_in[6] = 1'b1;
    idle(4);
    rd(5'h18, v); check("R6 rise on falling pin ignored", v, 32'h0000_0040);

    finish_run();
  end
endmodule